// File: doc/BRIEF.md
# Card Transfer Request Sequencer

This block follows a single memory-card request from the moment it is launched until it is reported complete. A start pulse carries the request's attributes: whether a data phase exists, its direction, whether a stop command follows, and whether data moves by DMA or by programmed I/O. After that the sequencer advances on per-cycle event strobes from the card interface: command finished, card status error, block finished, card entered busy, card left busy, and FIFO drained.

The route to completion depends on direction and mode. Writes wait until the card has left busy once for every requested block. DMA transfers also wait for the FIFO to drain. A stop command is requested at the right point. Timeout and CRC flags abort the normal route. An error during the data phase still issues the stop command when one was requested. At the end the block raises a one-cycle done pulse with separate error codes for the main command and the stop command, and it exposes the count of blocks written.

Top module: `card_req_seq`

## Requirements
- R1: After reset all outputs are low and the sequencer is idle. A start pulse while idle is accepted and the request enters its command phase on the next clock edge.
- R2: In the command phase, either a command-finished or a card-status-error strobe ends the phase. A request without data then completes. A request with data moves to its data phase. A card-status-error strobe on its own sets no error code.
- R3: In the data phase, a block-finished strobe sends a write to busy tracking. A DMA read goes to FIFO draining. A programmed-I/O read issues the stop command when one was requested and completes otherwise. stop_issue_o is a one-cycle pulse and is raised only for requests that carry a stop.
- R4: A busy-entry strobe sets a busy flag. A busy-exit strobe while the flag is set (or arriving in the same cycle as an entry) increments wr_blocks_o and clears the flag. A busy-exit strobe without the flag does not change wr_blocks_o. An accepted start clears both the flag and the count.
- R5: A write leaves busy tracking only when the flag is clear and wr_blocks_o equals the requested block count. It then goes to FIFO draining for DMA, or to the stop command or completion for programmed I/O.
- R6: FIFO draining ends on a FIFO-drained strobe. That strobe may also arrive earlier in the same request and is remembered until it is used. The sequencer then issues the stop command, or completes when there is none.
- R7: While the stop command runs, a command-finished strobe completes the request. Completion drives done_o high for exactly one cycle, after which the sequencer is idle. done_o and stop_issue_o are never high together.
- R8: Error codes are 2'b00 for none, 2'b01 for timeout (command or data timeout flag), and 2'b10 for CRC (command or data CRC flag). Timeout wins when both kinds are present. The codes stay valid from done_o until the next accepted start.
- R9: An error during the data phase, busy tracking or FIFO draining of a request with a stop is recorded on the main command, issues the stop command and waits for it. An error while the stop command runs is recorded on the stop command and completes the request. Any other error in an active state is recorded on the main command and completes the request.
- R10: A start pulse while the sequencer is not idle is rejected. reject_o is high on the following cycle, and the running request continues unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Launch a request |
| req_data_i | input | 1 | Request has a data phase |
| req_write_i | input | 1 | Data direction is write |
| req_stop_i | input | 1 | Request carries a stop command |
| req_dma_i | input | 1 | Data moves by DMA (else programmed I/O) |
| req_blocks_i | input | BLK_W | Requested block count |
| ev_cmd_end_i | input | 1 | Command phase finished |
| ev_card_err_i | input | 1 | Card status error |
| ev_blk_i | input | 1 | Block finished |
| ev_busy_on_i | input | 1 | Card entered busy |
| ev_busy_off_i | input | 1 | Card left busy |
| ev_fifo_i | input | 1 | FIFO drained |
| err_cto_i | input | 1 | Command timeout |
| err_dto_i | input | 1 | Data timeout |
| err_ccrc_i | input | 1 | Command CRC error |
| err_dcrc_i | input | 1 | Data CRC error |
| stop_issue_o | output | 1 | Issue stop command (pulse) |
| done_o | output | 1 | Request complete (pulse) |
| main_err_o | output | 2 | Main command error code |
| stop_err_o | output | 2 | Stop command error code |
| wr_blocks_o | output | BLK_W | Blocks written |
| reject_o | output | 1 | Start rejected (pulse) |

## Verification
The assertions assume that strobes are single-cycle and synchronous to the clock, that a requested block count is at least one, and that a stop command is completed only by a command-finished strobe delivered after stop_issue_o. The stimulus drives every strobe for exactly one cycle on the falling edge and allows two idle cycles after each stage before giving the stop completion. A sweep covers every combination of data, direction, stop and mode for one to three blocks. Directed runs then place errors in each active state, send busy-exit strobes without a matching entry, deliver the FIFO strobe early, and send a start while a request is running.

// File: rtl/card_req_seq_pkg.sv
package card_req_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_CMD, ST_XFER, ST_BUSYW, ST_DRAIN, ST_STOP, ST_READY
  } seq_state_e;

  localparam logic [1:0] ERR_NONE = 2'b00;
  localparam logic [1:0] ERR_TMO  = 2'b01;
  localparam logic [1:0] ERR_CRC  = 2'b10;

  typedef struct packed {
    logic data;
    logic write;
    logic stop;
    logic dma;
  } req_attr_t;
endpackage

// File: rtl/card_err_map.sv
module card_err_map
  import card_req_seq_pkg::*;
(
  input  logic       cto_i,
  input  logic       dto_i,
  input  logic       ccrc_i,
  input  logic       dcrc_i,
  output logic       any_o,
  output logic [1:0] code_o
);
  always_comb begin
    any_o = cto_i | dto_i | ccrc_i | dcrc_i;
    if (cto_i | dto_i)        code_o = ERR_TMO;  // timeout wins
    else if (ccrc_i | dcrc_i) code_o = ERR_CRC;
    else                      code_o = ERR_NONE;
  end
endmodule

// File: rtl/card_busy_track.sv
module card_busy_track #(
  parameter int CNT_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic             on_i,
  input  logic             off_i,
  output logic             busy_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (clr_i) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (en_i) begin
      if (off_i && (busy_q || on_i)) begin
        cnt_q  <= cnt_q + CNT_W'(1);
        busy_q <= 1'b0;
      end else if (on_i) begin
        busy_q <= 1'b1;
      end
    end
  end

  assign busy_o = busy_q;
  assign cnt_o  = cnt_q;

  assert_orphan_exit_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !clr_i && off_i && !on_i && !busy_q) |=> (cnt_q == $past(cnt_q)));

  assert_exit_counts_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !clr_i && off_i && busy_q) |=> (cnt_q == $past(cnt_q) + CNT_W'(1) && !busy_q));
endmodule

// File: rtl/card_seq_ctrl.sv
module card_seq_ctrl
  import card_req_seq_pkg::*;
#(
  parameter int BLK_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  req_attr_t        attr_i,
  input  logic [BLK_W-1:0] blocks_i,
  input  logic             ev_cmd_end_i,
  input  logic             ev_card_err_i,
  input  logic             ev_blk_i,
  input  logic             ev_fifo_i,
  input  logic             err_any_i,
  input  logic [1:0]       err_code_i,
  input  logic             busy_i,
  input  logic [BLK_W-1:0] wr_cnt_i,
  output logic             active_o,
  output logic             accept_o,
  output logic             stop_issue_o,
  output logic             done_o,
  output logic [1:0]       main_err_o,
  output logic [1:0]       stop_err_o,
  output logic             reject_o
);
  seq_state_e       state_q, state_d;
  req_attr_t        attr_q;
  logic [BLK_W-1:0] blk_q;
  logic [1:0]       main_q, main_d, stop_q, stop_d;
  logic             fifo_q, fifo_hit, stop_issue_q, reject_q;
  logic             accept, err_hit, data_err;
  seq_state_e       after_data, after_drain;

  assign accept   = start_i && (state_q == ST_IDLE);
  assign fifo_hit = fifo_q | ev_fifo_i;
  assign err_hit  = err_any_i && (state_q != ST_IDLE) && (state_q != ST_READY);
  assign data_err = (state_q == ST_XFER) || (state_q == ST_BUSYW) || (state_q == ST_DRAIN);

  always_comb begin
    after_drain = attr_q.stop ? ST_STOP : ST_READY;
    after_data  = attr_q.dma ? ST_DRAIN : after_drain;
  end

  always_comb begin
    state_d = state_q;
    main_d  = main_q;
    stop_d  = stop_q;
    unique case (state_q)
      ST_IDLE:  if (start_i) state_d = ST_CMD;
      ST_CMD:   if (ev_cmd_end_i || ev_card_err_i)
                  state_d = attr_q.data ? ST_XFER : ST_READY;
      ST_XFER:  if (ev_blk_i) state_d = attr_q.write ? ST_BUSYW : after_data;
      ST_BUSYW: if (!busy_i && wr_cnt_i == blk_q) state_d = after_data;
      ST_DRAIN: if (fifo_hit) state_d = after_drain;
      ST_STOP:  if (ev_cmd_end_i) state_d = ST_READY;
      ST_READY: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
    if (err_hit) begin
      if (state_q == ST_STOP) begin
        stop_d  = err_code_i;
        state_d = ST_READY;
      end else if (attr_q.stop && data_err) begin
        main_d  = err_code_i;
        state_d = ST_STOP;
      end else begin
        main_d  = err_code_i;
        state_d = ST_READY;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      attr_q       <= '0;
      blk_q        <= '0;
      main_q       <= ERR_NONE;
      stop_q       <= ERR_NONE;
      fifo_q       <= 1'b0;
      stop_issue_q <= 1'b0;
      reject_q     <= 1'b0;
    end else begin
      state_q      <= state_d;
      stop_issue_q <= (state_d == ST_STOP) && (state_q != ST_STOP);
      reject_q     <= start_i && (state_q != ST_IDLE);
      if (accept) begin
        attr_q <= attr_i;
        blk_q  <= blocks_i;
        main_q <= ERR_NONE;
        stop_q <= ERR_NONE;
        fifo_q <= 1'b0;
      end else begin
        main_q <= main_d;
        stop_q <= stop_d;
        if (state_q == ST_DRAIN && fifo_hit) fifo_q <= 1'b0;
        else if (ev_fifo_i && state_q != ST_IDLE) fifo_q <= 1'b1;  // early drain is remembered
      end
    end
  end

  assign active_o     = (state_q != ST_IDLE);
  assign accept_o     = accept;
  assign stop_issue_o = stop_issue_q;
  assign done_o       = (state_q == ST_READY);
  assign main_err_o   = main_q;
  assign stop_err_o   = stop_q;
  assign reject_o     = reject_q;

  assert_start_to_cmd_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && state_q == ST_IDLE) |=> (state_q == ST_CMD));

  assert_stop_only_if_req_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_issue_o |-> (attr_q.stop && state_q == ST_STOP));

  assert_wait_while_busy_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_BUSYW && busy_i && !err_any_i) |=> (state_q == ST_BUSYW));

  assert_done_then_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (state_q == ST_IDLE && !done_o));

  assert_done_stop_excl_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({done_o, stop_issue_o}));

  assert_reject_busy_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && state_q != ST_IDLE) |=> (reject_o && $stable(blk_q)));
endmodule

// File: rtl/card_req_seq.sv
module card_req_seq
  import card_req_seq_pkg::*;
#(
  parameter int MAX_BLOCKS = 256,
  localparam int BLK_W = $clog2(MAX_BLOCKS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             req_data_i,
  input  logic             req_write_i,
  input  logic             req_stop_i,
  input  logic             req_dma_i,
  input  logic [BLK_W-1:0] req_blocks_i,
  input  logic             ev_cmd_end_i,
  input  logic             ev_card_err_i,
  input  logic             ev_blk_i,
  input  logic             ev_busy_on_i,
  input  logic             ev_busy_off_i,
  input  logic             ev_fifo_i,
  input  logic             err_cto_i,
  input  logic             err_dto_i,
  input  logic             err_ccrc_i,
  input  logic             err_dcrc_i,
  output logic             stop_issue_o,
  output logic             done_o,
  output logic [1:0]       main_err_o,
  output logic [1:0]       stop_err_o,
  output logic [BLK_W-1:0] wr_blocks_o,
  output logic             reject_o
);
  req_attr_t        attr;
  logic             err_any, busy, active, accept;
  logic [1:0]       err_code;
  logic [BLK_W-1:0] wr_cnt;

  assign attr = '{data: req_data_i, write: req_write_i, stop: req_stop_i, dma: req_dma_i};

  card_err_map u_err (
    .cto_i (err_cto_i),
    .dto_i (err_dto_i),
    .ccrc_i(err_ccrc_i),
    .dcrc_i(err_dcrc_i),
    .any_o (err_any),
    .code_o(err_code)
  );

  card_busy_track #(.CNT_W(BLK_W)) u_busy (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (accept),
    .en_i  (active),
    .on_i  (ev_busy_on_i),
    .off_i (ev_busy_off_i),
    .busy_o(busy),
    .cnt_o (wr_cnt)
  );

  card_seq_ctrl #(.BLK_W(BLK_W)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .attr_i       (attr),
    .blocks_i     (req_blocks_i),
    .ev_cmd_end_i (ev_cmd_end_i),
    .ev_card_err_i(ev_card_err_i),
    .ev_blk_i     (ev_blk_i),
    .ev_fifo_i    (ev_fifo_i),
    .err_any_i    (err_any),
    .err_code_i   (err_code),
    .busy_i       (busy),
    .wr_cnt_i     (wr_cnt),
    .active_o     (active),
    .accept_o     (accept),
    .stop_issue_o (stop_issue_o),
    .done_o       (done_o),
    .main_err_o   (main_err_o),
    .stop_err_o   (stop_err_o),
    .reject_o     (reject_o)
  );

  assign wr_blocks_o = wr_cnt;

  assert_err_code_valid_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (main_err_o != 2'b11 && stop_err_o != 2'b11));
endmodule

// File: tb/card_req_seq_test.sv
module card_req_seq_test;
  localparam int MAXB = 256;
  localparam int BW   = $clog2(MAXB + 1);

  localparam logic [9:0] E_EOC  = 10'b1000000000;
  localparam logic [9:0] E_CERR = 10'b0100000000;
  localparam logic [9:0] E_BLK  = 10'b0010000000;
  localparam logic [9:0] E_BON  = 10'b0001000000;
  localparam logic [9:0] E_BOFF = 10'b0000100000;
  localparam logic [9:0] E_FIFO = 10'b0000010000;
  localparam logic [9:0] E_CTO  = 10'b0000001000;
  localparam logic [9:0] E_DTO  = 10'b0000000100;
  localparam logic [9:0] E_CCRC = 10'b0000000010;
  localparam logic [9:0] E_DCRC = 10'b0000000001;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, r_data = 0, r_write = 0, r_stop = 0, r_dma = 0;
  logic [BW-1:0] r_blocks = '0;
  logic ev_eoc = 0, ev_cerr = 0, ev_blk = 0, ev_bon = 0, ev_boff = 0, ev_fifo = 0;
  logic e_cto = 0, e_dto = 0, e_ccrc = 0, e_dcrc = 0;
  logic stop_issue, done, reject;
  logic [1:0] main_err, stop_err;
  logic [BW-1:0] wr_blocks;

  int checks = 0, fails = 0;
  int done_cnt = 0, stop_cnt = 0, rej_cnt = 0;
  logic [1:0] last_main, last_stop;
  bit wd = 0;

  always #10 clk = ~clk;

  card_req_seq #(.MAX_BLOCKS(MAXB)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .req_data_i(r_data), .req_write_i(r_write), .req_stop_i(r_stop), .req_dma_i(r_dma),
    .req_blocks_i(r_blocks),
    .ev_cmd_end_i(ev_eoc), .ev_card_err_i(ev_cerr), .ev_blk_i(ev_blk),
    .ev_busy_on_i(ev_bon), .ev_busy_off_i(ev_boff), .ev_fifo_i(ev_fifo),
    .err_cto_i(e_cto), .err_dto_i(e_dto), .err_ccrc_i(e_ccrc), .err_dcrc_i(e_dcrc),
    .stop_issue_o(stop_issue), .done_o(done), .main_err_o(main_err), .stop_err_o(stop_err),
    .wr_blocks_o(wr_blocks), .reject_o(reject)
  );

  always @(negedge clk) begin
    if (done) begin
      done_cnt++;
      last_main = main_err;
      last_stop = stop_err;
    end
    if (stop_issue) stop_cnt++;
    if (reject) rej_cnt++;
  end

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic step(input logic [9:0] v);
    {ev_eoc, ev_cerr, ev_blk, ev_bon, ev_boff, ev_fifo, e_cto, e_dto, e_ccrc, e_dcrc} = v;
    @(negedge clk);
    {ev_eoc, ev_cerr, ev_blk, ev_bon, ev_boff, ev_fifo, e_cto, e_dto, e_ccrc, e_dcrc} = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic launch(input bit d, input bit w, input bit s, input bit m, input int n);
    done_cnt = 0; stop_cnt = 0; rej_cnt = 0;
    start = 1; r_data = d; r_write = w; r_stop = s; r_dma = m; r_blocks = BW'(n);
    @(negedge clk);
    start = 0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 12 && done_cnt == 0; i++) idle(1);
    idle(2);
  endtask

  task automatic run_normal(input bit d, input bit w, input bit s, input bit m, input int n);
    launch(d, w, s, m, n);
    idle(1);
    step(E_EOC);
    if (d) begin
      step(E_BLK);
      if (w) for (int b = 0; b < n; b++) begin step(E_BON); step(E_BOFF); end
      if (m) step(E_FIFO);
    end
    idle(2);
    if (s) step(E_EOC);
    wait_done();
    chk(done_cnt == 1, "R2/R7 one done pulse", done_cnt, 1);
    chk(stop_cnt == ((d && s) ? 1 : 0), "R3/R5/R6 stop pulses", stop_cnt, (d && s) ? 1 : 0);
    chk(last_main == 2'b00 && last_stop == 2'b00, "R8 no error", {last_main, last_stop}, 0);
    chk(int'(wr_blocks) == ((d && w) ? n : 0), "R4 written blocks", wr_blocks, (d && w) ? n : 0);
  endtask

  task automatic run_all();
    idle(1);
    // R1: reset state
    chk({done, stop_issue, reject, main_err, stop_err} == 0, "R1 reset outputs", done, 0);
    chk(wr_blocks == 0, "R1 reset count", wr_blocks, 0);
    rst_n = 1;
    idle(2);

    for (int d = 0; d < 2; d++)
      for (int w = 0; w < 2; w++)
        for (int s = 0; s < 2; s++)
          for (int m = 0; m < 2; m++)
            for (int n = 1; n <= 3; n++)
              run_normal(d[0], w[0], s[0], m[0], n);

    // R5: completion waits for all blocks
    launch(1, 1, 0, 0, 2); idle(1);
    step(E_EOC); step(E_BLK); step(E_BON); step(E_BOFF); idle(3);
    chk(done_cnt == 0, "R5 waits for second block", done_cnt, 0);
    chk(wr_blocks == 1, "R5 partial count", wr_blocks, 1);
    step(E_BON); step(E_BOFF); wait_done();
    chk(done_cnt == 1 && wr_blocks == 2, "R5 completes at count", wr_blocks, 2);

    // R4: busy exit without entry is ignored; same-cycle entry+exit counts
    launch(1, 1, 0, 0, 2); idle(1);
    step(E_EOC); step(E_BLK); step(E_BOFF); idle(2);
    chk(wr_blocks == 0 && done_cnt == 0, "R4 orphan exit ignored", wr_blocks, 0);
    step(E_BON | E_BOFF); idle(1);
    chk(wr_blocks == 1, "R4 same-cycle entry and exit", wr_blocks, 1);
    step(E_BON); step(E_BOFF); wait_done();
    chk(done_cnt == 1 && wr_blocks == 2, "R4 count after completion", wr_blocks, 2);
    launch(0, 0, 0, 0, 1); idle(1);
    chk(wr_blocks == 0, "R4 count cleared by start", wr_blocks, 0);
    step(E_EOC); wait_done();

    // R6: DMA read waits for drain; early drain is remembered
    launch(1, 0, 0, 1, 1); idle(1);
    step(E_EOC); step(E_BLK); idle(5);
    chk(done_cnt == 0, "R6 waits for drain", done_cnt, 0);
    step(E_FIFO); wait_done();
    chk(done_cnt == 1, "R6 drain completes", done_cnt, 1);
    launch(1, 0, 1, 1, 1); idle(1);
    step(E_EOC); step(E_FIFO); step(E_BLK); idle(3);
    chk(stop_cnt == 1, "R6 early drain then stop", stop_cnt, 1);
    step(E_EOC); wait_done();
    chk(done_cnt == 1, "R6 early drain done", done_cnt, 1);

    // R2: card status error ends command phase without a code
    launch(0, 0, 0, 0, 1); idle(1);
    step(E_CERR); wait_done();
    chk(done_cnt == 1 && last_main == 2'b00, "R2 status error ends phase", last_main, 0);

    // R9: error in command phase goes straight to completion
    launch(1, 0, 1, 0, 1); idle(1);
    step(E_CTO); wait_done();
    chk(done_cnt == 1 && stop_cnt == 0, "R9 command phase error", stop_cnt, 0);
    chk(last_main == 2'b01, "R8 timeout code", last_main, 1);

    // R9: data error with stop issues stop, then completes
    launch(1, 0, 1, 0, 1); idle(1);
    step(E_EOC); step(E_DCRC); idle(2);
    chk(stop_cnt == 1 && done_cnt == 0, "R9 data error issues stop", stop_cnt, 1);
    step(E_EOC); wait_done();
    chk(last_main == 2'b10 && last_stop == 2'b00, "R8 CRC code on main", last_main, 2);

    // R9: error during stop goes to stop code; R8 timeout beats CRC
    launch(1, 0, 1, 0, 1); idle(1);
    step(E_EOC); step(E_BLK); idle(2);
    step(E_DTO | E_CCRC); wait_done();
    chk(done_cnt == 1 && last_stop == 2'b01 && last_main == 2'b00, "R8/R9 stop error priority", last_stop, 1);

    // R9: drain error without stop completes
    launch(1, 0, 0, 1, 1); idle(1);
    step(E_EOC); step(E_BLK); step(E_CCRC); wait_done();
    chk(done_cnt == 1 && stop_cnt == 0 && last_main == 2'b10, "R9 drain error no stop", last_main, 2);

    // R9: busy tracking error with stop
    launch(1, 1, 1, 1, 2); idle(1);
    step(E_EOC); step(E_BLK); step(E_CTO | E_DCRC); idle(2);
    chk(stop_cnt == 1, "R9 busy error issues stop", stop_cnt, 1);
    step(E_EOC); wait_done();
    chk(done_cnt == 1 && last_main == 2'b01, "R9 busy error code", last_main, 1);

    // R10: start while running is rejected
    launch(0, 0, 0, 0, 1);
    start = 1; r_blocks = BW'(7); @(negedge clk); start = 0;
    idle(1);
    chk(rej_cnt == 1, "R10 reject pulse", rej_cnt, 1);
    step(E_EOC); wait_done();
    chk(done_cnt == 1 && wr_blocks == 0, "R10 request unaffected", done_cnt, 1);
  endtask

  initial begin
    fork
      run_all();
      begin repeat (100000) @(posedge clk); wd = 1; end
    join_any
    disable fork;
    if (wd) begin
      checks++; fails++;
      $display("FAIL watchdog R1-all actual=%0d expected=%0d", 1, 0);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule